// File: doc/BRIEF.md
# Crypto Peripheral Access-Violation Monitor

This block is the register front end of a block-cipher peripheral. It sits on a simple APB-style register bus with zero wait states. It holds the key, input-data and initialization-vector words and a mode word, and drives them to the cipher core. It returns the output-data words and a constant version word on reads. It also carries the interrupt mask with its set and clear ports, the status word, and the interrupt line.

The core reports its phase on three inputs: processing, subkey generation and DMA mode. The front end checks every completed bus access against that phase. An access that is not allowed in the current phase sets a sticky detection flag and leaves a 3-bit code for the most recent violation type. A forbidden write is also kept from reaching its target register. A read of a write-only register returns zero and is logged as well. Writing bit 0 of the software-reset register clears the detection flag, the type code and the interrupt mask.

Top module: `crypt_access_monitor`

## Requirements
- R1: After the synchronous active-low reset, the mask reads 0 and the status reads 0 apart from the live core flags. The mode, key, input-data and IV outputs are 0, and `irq_o` is 0.
- R2: The mode word at 0x04 reads back what was written. Key, input-data and IV words at 0x20, 0x40 and 0x60 (word i at base+4i) appear on `key_o`, `din_o` and `iv_o` at bits [32i+31:32i]. Output words at 0x50+4i return `dout_i` word i. 0xFC returns the version parameter, and writes to it are ignored.
- R3: A write to 0x10 sets each mask bit whose data bit is 1, and a write to 0x14 clears each such bit. Zero data bits have no effect. Only mask bits 0..4 and 8 exist, and the mask reads at 0x18.
- R4: The status word at 0x1C has these bits: 0 data ready, 1 receive end, 2 transmit end, 3 receive full, 4 transmit empty, 8 violation detected, 14:12 violation type. All other bits are 0.
- R5: `irq_o` is the OR of status bits 0..4 and 8, each ANDed with its mask bit. The type field never raises it.
- R6: The violation codes are as follows. 0 is an input-data write while processing in DMA mode. 1 is an output-data read while processing. 2 is a mode write while processing. 3 is an output-data read during subkey generation. 4 is a mode write during subkey generation.
- R7: Reading a write-only register (0x00, 0x10, 0x14, the key, input-data and IV words) returns 0 and logs code 5.
- R8: When one access matches several rules, the lowest code is recorded.
- R9: The detection flag is set by the edge that completes a violating access and stays set. It is cleared only by a write with bit 0 set at 0x00, which also clears the type and the mask. That write is never a violation, and a write there with bit 0 clear does nothing.
- R10: Each new violation overwrites the type code. An access that violates nothing leaves the code unchanged.
- R11: A violating write does not change its target register. An input-data write while processing but not in DMA mode is legal and takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase; the access completes on the edge where psel and penable are both high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| eng_busy_i | input | 1 | Core is processing |
| eng_subkey_i | input | 1 | Core is generating subkeys |
| eng_dma_i | input | 1 | Core is fed by DMA |
| dout_i | input | 128 | Result block from the core |
| drdy_i | input | 1 | Data-ready flag |
| rx_end_i | input | 1 | Receive buffer end flag |
| tx_end_i | input | 1 | Transmit buffer end flag |
| rx_full_i | input | 1 | Receive buffers full flag |
| tx_empty_i | input | 1 | Transmit buffers empty flag |
| key_o | output | 128 | Key block |
| din_o | output | 128 | Input data block |
| iv_o | output | 128 | Initialization vector block |
| mode_o | output | 32 | Mode word |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions meet on one access here. A mode or input-data write in a forbidden phase must log its code and also leave the target register untouched. The bench issues such writes and compares the register outputs against its model on the following cycle, while the status read checks the logged code.

Two rules can also match one access. The bench asserts processing and subkey generation together and then issues an output read and a mode write. It expects codes 1 and 2, not 3 and 4.

The interrupt line is judged on every clock against the model. This covers the cycle in which a violation sets bit 8 while that bit is unmasked.

// File: rtl/crypt_fe_pkg.sv
// Shared constants and types for the crypto register front end.
// Assumes an 8-bit byte address space and 32-bit words.
package crypt_fe_pkg;

    localparam int unsigned AW = 8;

    // Register offsets
    localparam logic [AW-1:0] OFS_SWRST = 8'h00;
    localparam logic [AW-1:0] OFS_MODE  = 8'h04;
    localparam logic [AW-1:0] OFS_IEN   = 8'h10;
    localparam logic [AW-1:0] OFS_IDIS  = 8'h14;
    localparam logic [AW-1:0] OFS_IMASK = 8'h18;
    localparam logic [AW-1:0] OFS_ISTAT = 8'h1C;
    localparam logic [AW-1:0] OFS_KEY   = 8'h20;
    localparam logic [AW-1:0] OFS_DIN   = 8'h40;
    localparam logic [AW-1:0] OFS_DOUT  = 8'h50;
    localparam logic [AW-1:0] OFS_IV    = 8'h60;
    localparam logic [AW-1:0] OFS_VER   = 8'hFC;

    // Status bit positions
    localparam int unsigned ST_FLAGS_N = 5;
    localparam int unsigned ST_VIOL    = 8;
    localparam int unsigned ST_TYPE_LO = 12;

    // Mask bits that exist
    localparam logic [31:0] MASK_IMPL = 32'h0000_011F;

    // Violation codes; numeric order is the priority order
    typedef enum logic [2:0] {
        VT_DIN_DMA     = 3'd0,
        VT_DOUT_PROC   = 3'd1,
        VT_MODE_PROC   = 3'd2,
        VT_DOUT_SUBKEY = 3'd3,
        VT_MODE_SUBKEY = 3'd4,
        VT_WO_READ     = 3'd5
    } viol_t;

    // One-hot region hit from the address decoder
    typedef struct packed {
        logic swrst;
        logic mode;
        logic ien;
        logic idis;
        logic imask;
        logic istat;
        logic key;
        logic din;
        logic dout;
        logic iv;
        logic ver;
    } region_t;

endpackage

// File: rtl/cfe_addr_decode.sv
// Address decoder: maps a byte address to a region and a word index.
// Assumes word-aligned accesses; an unaligned address hits nothing.
// A block region spans NWORDS words starting at its base offset.
module cfe_addr_decode
    import crypt_fe_pkg::*;
#(
    parameter int unsigned NWORDS = 4,
    localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int unsigned SPAN_LSB = WIDX_W + 2
)(
    input  logic [AW-1:0]     addr,
    output region_t           hit,
    output logic [WIDX_W-1:0] widx,
    output logic              wo
);

    // True when the address falls inside a block region
    function automatic logic in_block(input logic [AW-1:0] a, input logic [AW-1:0] base);
        return (a[AW-1:SPAN_LSB] == base[AW-1:SPAN_LSB])
            && (32'(a[SPAN_LSB-1:2]) < NWORDS)
            && (a[1:0] == 2'b00);
    endfunction

    // Region decode
    always_comb begin
        hit.swrst = (addr == OFS_SWRST);
        hit.mode  = (addr == OFS_MODE);
        hit.ien   = (addr == OFS_IEN);
        hit.idis  = (addr == OFS_IDIS);
        hit.imask = (addr == OFS_IMASK);
        hit.istat = (addr == OFS_ISTAT);
        hit.ver   = (addr == OFS_VER);
        hit.key   = in_block(addr, OFS_KEY);
        hit.din   = in_block(addr, OFS_DIN);
        hit.dout  = in_block(addr, OFS_DOUT);
        hit.iv    = in_block(addr, OFS_IV);
    end

    assign widx = addr[SPAN_LSB-1:2];

    // Registers that may only be written
    assign wo = hit.swrst | hit.ien | hit.idis | hit.key | hit.din | hit.iv;

endmodule

// File: rtl/cfe_viol_detect.sv
// Phase checker: classifies a completed access against the engine phase.
// Pure combinational; the rule order gives lowest-code priority.
module cfe_viol_detect
    import crypt_fe_pkg::*;
(
    input  logic  rd,
    input  logic  wr,
    input  logic  is_din,
    input  logic  is_dout,
    input  logic  is_mode,
    input  logic  is_wo,
    input  logic  busy,
    input  logic  subkey,
    input  logic  dma,
    output logic  viol,
    output viol_t code
);

    // Priority chain, lowest code first
    always_comb begin
        viol = 1'b1;
        code = VT_DIN_DMA;
        if (wr && is_din && busy && dma) begin
            code = VT_DIN_DMA;
        end else if (rd && is_dout && busy) begin
            code = VT_DOUT_PROC;
        end else if (wr && is_mode && busy) begin
            code = VT_MODE_PROC;
        end else if (rd && is_dout && subkey) begin
            code = VT_DOUT_SUBKEY;
        end else if (wr && is_mode && subkey) begin
            code = VT_MODE_SUBKEY;
        end else if (rd && is_wo) begin
            code = VT_WO_READ;
        end else begin
            viol = 1'b0;
        end
    end

endmodule

// File: rtl/cfe_word_bank.sv
// Bank of NWORDS writable words packed into one flat vector.
// Word i sits at bits [i*DW +: DW]; one word is written per enable.
module cfe_word_bank #(
    parameter int unsigned NWORDS = 4,
    parameter int unsigned DW = 32,
    localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [WIDX_W-1:0]    widx,
    input  logic [DW-1:0]        wdata,
    output logic [NWORDS*DW-1:0] q
);

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        // Hold one word, load it when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g*DW +: DW] <= '0;
            end else if (we && (widx == WIDX_W'(g))) begin
                q[g*DW +: DW] <= wdata;
            end
        end
    end

endmodule

// File: rtl/cfe_irq_ctrl.sv
// Interrupt mask, sticky violation flag, last violation type and irq.
// Assumes at most one of set, clear and soft-reset per cycle (one bus access).
module cfe_irq_ctrl
    import crypt_fe_pkg::*;
#(
    parameter int unsigned DW = 32
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_we,
    input  logic                  dis_we,
    input  logic                  clr,
    input  logic [DW-1:0]         wdata,
    input  logic                  viol,
    input  viol_t                 code,
    input  logic [ST_FLAGS_N-1:0] flags,
    output logic [DW-1:0]         mask_q,
    output logic                  detect_q,
    output viol_t                 vtype_q,
    output logic [DW-1:0]         status,
    output logic                  irq
);

    localparam logic [DW-1:0] IMPL = DW'(MASK_IMPL);

    // Mask bits: set port, clear port, soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask_q <= '0;
        end else if (en_we) begin
            mask_q <= mask_q | (wdata & IMPL);
        end else if (dis_we) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    // Sticky detection flag and last violation code
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            detect_q <= 1'b0;
            vtype_q  <= VT_DIN_DMA;
        end else if (viol) begin
            detect_q <= 1'b1;
            vtype_q  <= code;
        end
    end

    // Status word assembly
    always_comb begin
        status = '0;
        status[ST_FLAGS_N-1:0] = flags;
        status[ST_VIOL] = detect_q;
        status[ST_TYPE_LO +: 3] = vtype_q;
    end

    // Interrupt: enabled status bits up to the detection flag
    assign irq = |(status[ST_VIOL:0] & mask_q[ST_VIOL:0]);

endmodule

// File: rtl/crypt_access_monitor.sv
// Register front end of a block-cipher peripheral with phase-dependent
// access-violation logging. Zero-wait bus: an access completes on the
// edge where psel and penable are both high. Assumes the core phase
// inputs are stable across an access.
module crypt_access_monitor
    import crypt_fe_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned NWORDS = 4,
    parameter logic [DW-1:0] VERSION = 32'h0000_0130,
    localparam int unsigned BLK_W = NWORDS * DW,
    localparam int unsigned WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    input  logic             eng_busy_i,
    input  logic             eng_subkey_i,
    input  logic             eng_dma_i,
    input  logic [BLK_W-1:0] dout_i,
    input  logic             drdy_i,
    input  logic             rx_end_i,
    input  logic             tx_end_i,
    input  logic             rx_full_i,
    input  logic             tx_empty_i,
    output logic [BLK_W-1:0] key_o,
    output logic [BLK_W-1:0] din_o,
    output logic [BLK_W-1:0] iv_o,
    output logic [DW-1:0]    mode_o,
    output logic             irq_o
);

    logic                  acc, rd_acc, wr_acc;
    region_t               hit;
    logic [WIDX_W-1:0]     widx;
    logic                  wo_reg;
    logic                  viol_hit;
    viol_t                 viol_code;
    logic [DW-1:0]         mask_q, status_w, mode_q, dout_word;
    logic                  detect_q;
    viol_t                 vtype_q;
    logic [ST_FLAGS_N-1:0] core_flags;
    logic                  key_we, din_we, iv_we, mode_we;
    logic                  en_we, dis_we, soft_clr;

    // Completed access qualifiers
    assign acc    = psel & penable;
    assign rd_acc = acc & ~pwrite;
    assign wr_acc = acc & pwrite;

    cfe_addr_decode #(.NWORDS(NWORDS)) i_decode (
        .addr (paddr),
        .hit  (hit),
        .widx (widx),
        .wo   (wo_reg)
    );

    cfe_viol_detect i_detect (
        .rd      (rd_acc),
        .wr      (wr_acc),
        .is_din  (hit.din),
        .is_dout (hit.dout),
        .is_mode (hit.mode),
        .is_wo   (wo_reg),
        .busy    (eng_busy_i),
        .subkey  (eng_subkey_i),
        .dma     (eng_dma_i),
        .viol    (viol_hit),
        .code    (viol_code)
    );

    // Write enables; violating writes are blocked
    assign key_we   = wr_acc & hit.key;
    assign iv_we    = wr_acc & hit.iv;
    assign din_we   = wr_acc & hit.din & ~viol_hit;
    assign mode_we  = wr_acc & hit.mode & ~viol_hit;
    assign en_we    = wr_acc & hit.ien;
    assign dis_we   = wr_acc & hit.idis;
    assign soft_clr = wr_acc & hit.swrst & pwdata[0];

    cfe_word_bank #(.NWORDS(NWORDS), .DW(DW)) i_key_bank (
        .clk (clk), .rst_n (rst_n), .we (key_we), .widx (widx), .wdata (pwdata), .q (key_o)
    );

    cfe_word_bank #(.NWORDS(NWORDS), .DW(DW)) i_din_bank (
        .clk (clk), .rst_n (rst_n), .we (din_we), .widx (widx), .wdata (pwdata), .q (din_o)
    );

    cfe_word_bank #(.NWORDS(NWORDS), .DW(DW)) i_iv_bank (
        .clk (clk), .rst_n (rst_n), .we (iv_we), .widx (widx), .wdata (pwdata), .q (iv_o)
    );

    // Mode word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= pwdata;
        end
    end

    assign mode_o = mode_q;
    assign core_flags = {tx_empty_i, rx_full_i, tx_end_i, rx_end_i, drdy_i};

    cfe_irq_ctrl #(.DW(DW)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (en_we),
        .dis_we   (dis_we),
        .clr      (soft_clr),
        .wdata    (pwdata),
        .viol     (viol_hit),
        .code     (viol_code),
        .flags    (core_flags),
        .mask_q   (mask_q),
        .detect_q (detect_q),
        .vtype_q  (vtype_q),
        .status   (status_w),
        .irq      (irq_o)
    );

    // Select the addressed result word
    always_comb begin
        dout_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (widx == WIDX_W'(w)) begin
                dout_word = dout_i[w*DW +: DW];
            end
        end
    end

    // Read data mux; write-only and unmapped addresses read zero
    always_comb begin
        if (hit.mode) begin
            prdata = mode_q;
        end else if (hit.imask) begin
            prdata = mask_q;
        end else if (hit.istat) begin
            prdata = status_w;
        end else if (hit.dout) begin
            prdata = dout_word;
        end else if (hit.ver) begin
            prdata = VERSION;
        end else begin
            prdata = '0;
        end
    end

endmodule

// File: rtl/cfe_checker.sv
// Property checker for crypt_access_monitor, attached by bind.
// Decodes the addresses it needs on its own from the package offsets.
module cfe_checker
    import crypt_fe_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned NWORDS = 4
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [AW-1:0]        paddr,
    input logic [DW-1:0]        pwdata,
    input logic [DW-1:0]        prdata,
    input logic                 busy,
    input logic                 subkey,
    input logic                 dma,
    input logic                 irq,
    input logic [DW-1:0]        mode_o,
    input logic [NWORDS*DW-1:0] din_o,
    input logic [DW-1:0]        mask,
    input logic                 detect,
    input logic [2:0]           vtype,
    input logic                 viol
);

    logic acc, rd, wr, clr, din_a, wo_a;

    assign acc   = psel && penable;
    assign rd    = acc && !pwrite;
    assign wr    = acc && pwrite;
    assign clr   = wr && (paddr == OFS_SWRST) && pwdata[0];
    assign din_a = (paddr[7:4] == OFS_DIN[7:4]) && (paddr[1:0] == 2'b00);
    assign wo_a  = (paddr == OFS_SWRST) || (paddr == OFS_IEN) || (paddr == OFS_IDIS) || din_a
                || (((paddr[7:4] == OFS_KEY[7:4]) || (paddr[7:4] == OFS_IV[7:4])) && (paddr[1:0] == 2'b00));

    AST_DETECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (detect && !clr) |=> detect); // R9

    AST_VIOL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> detect); // R9

    AST_VIOL_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> acc); // R6

    AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol && !clr) |=> $stable(vtype)); // R10

    AST_MODE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (paddr == OFS_MODE) && (busy || subkey)) |=> $stable(mode_o)); // R11

    AST_DIN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && din_a && busy && dma) |=> $stable(din_o)); // R11

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wo_a) |-> (prdata == '0)); // R7

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[8:0] == 9'd0) |-> !irq); // R5

endmodule

bind crypt_access_monitor cfe_checker #(.DW(DW), .NWORDS(NWORDS)) i_cfe_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .busy    (eng_busy_i),
    .subkey  (eng_subkey_i),
    .dma     (eng_dma_i),
    .irq     (irq_o),
    .mode_o  (mode_o),
    .din_o   (din_o),
    .mask    (mask_q),
    .detect  (detect_q),
    .vtype   (vtype_q),
    .viol    (viol_hit)
);

// File: tb/test_crypt_access_monitor.sv
// Self-checking bench with a behavioural reference model compared every clock.
module test_crypt_access_monitor;

    localparam int CLK_P = 10;
    localparam int NW = 4;
    localparam logic [31:0] VER_EXP = 32'h0000_0130;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]   paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         busy = 1'b0, subkey = 1'b0, dma = 1'b0;
    logic [127:0] dout = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [4:0]   flags = '0;
    logic [127:0] key_o, din_o, iv_o;
    logic [31:0]  mode_o;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    logic [31:0] m_key[NW];
    logic [31:0] m_din[NW];
    logic [31:0] m_iv[NW];
    logic [31:0] m_mode = '0;
    logic [31:0] m_mask = '0;
    bit          m_det = 1'b0;
    int          m_type = 0;

    always #(CLK_P/2) clk = ~clk;

    crypt_access_monitor #(.VERSION(VER_EXP)) i_crypt_access_monitor (
        .clk (clk), .rst_n (rst_n), .psel (psel), .penable (penable), .pwrite (pwrite),
        .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .eng_busy_i (busy), .eng_subkey_i (subkey), .eng_dma_i (dma), .dout_i (dout),
        .drdy_i (flags[0]), .rx_end_i (flags[1]), .tx_end_i (flags[2]),
        .rx_full_i (flags[3]), .tx_empty_i (flags[4]),
        .key_o (key_o), .din_o (din_o), .iv_o (iv_o), .mode_o (mode_o), .irq_o (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit in_blk(input logic [7:0] a, input logic [7:0] base);
        return (a[7:4] == base[7:4]) && (a[1:0] == 2'b00);
    endfunction

    // Expected violation code of an access, -1 when legal
    function automatic int exp_code(input logic [7:0] a, input bit w);
        if (w) begin
            if (in_blk(a, 8'h40) && busy && dma) return 0;
            if (a == 8'h04 && busy) return 2;
            if (a == 8'h04 && subkey) return 4;
            return -1;
        end
        if (in_blk(a, 8'h50)) begin
            if (busy) return 1;
            if (subkey) return 3;
            return -1;
        end
        if (a == 8'h00 || a == 8'h10 || a == 8'h14 || in_blk(a, 8'h20)
            || in_blk(a, 8'h40) || in_blk(a, 8'h60)) return 5;
        return -1;
    endfunction

    function automatic logic [31:0] m_status();
        return {17'b0, 3'(m_type), 3'b0, m_det, 3'b0, flags};
    endfunction

    function automatic bit exp_irq();
        return (({m_det, 3'b0, flags} & m_mask[8:0]) != 9'd0);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h04) return m_mode;
        if (a == 8'h18) return m_mask;
        if (a == 8'h1C) return m_status();
        if (a == 8'hFC) return VER_EXP;
        if (in_blk(a, 8'h50)) return dout[32*a[3:2] +: 32];
        return 32'h0;
    endfunction

    function automatic logic [127:0] pack4(input logic [31:0] w[NW]);
        return {w[3], w[2], w[1], w[0]};
    endfunction

    // Legal write effect on the model
    function automatic void apply(input logic [7:0] a, input logic [31:0] d);
        if (in_blk(a, 8'h20)) m_key[a[3:2]] = d;
        else if (in_blk(a, 8'h40)) m_din[a[3:2]] = d;
        else if (in_blk(a, 8'h60)) m_iv[a[3:2]] = d;
        else if (a == 8'h04) m_mode = d;
        else if (a == 8'h10) m_mask = m_mask | (d & 32'h0000_011F);
        else if (a == 8'h14) m_mask = m_mask & ~d;
        else if (a == 8'h00 && d[0]) begin
            m_det = 1'b0; m_type = 0; m_mask = '0;
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int c;
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(posedge clk);
        c = exp_code(a, 1'b1);
        if (c >= 0) begin m_det = 1'b1; m_type = c; end
        else apply(a, d);
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        int c;
        logic [31:0] e;
        @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        e = exp_read(a);
        #(CLK_P/4);
        check(prdata === e, req, $sformatf("read 0x%h", a), 128'(prdata), 128'(e));
        @(posedge clk);
        c = exp_code(a, 1'b0);
        if (c >= 0) begin m_det = 1'b1; m_type = c; end
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic phase(input bit b, input bit s, input bit d);
        @(negedge clk); busy = b; subkey = s; dma = d;
    endtask

    task automatic set_flags(input logic [4:0] f);
        @(negedge clk); flags = f;
    endtask

    task automatic chk_irq(input bit e, input string req);
        @(negedge clk); #1;
        check(irq === e, req, "irq", 128'(irq), 128'(e));
    endtask

    // Cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            check(irq === exp_irq(), "R5", "irq per cycle", 128'(irq), 128'(exp_irq()));
            check(mode_o === m_mode, "R11", "mode_o", 128'(mode_o), 128'(m_mode));
            check(din_o === pack4(m_din), "R11", "din_o", din_o, pack4(m_din));
            check(key_o === pack4(m_key), "R2", "key_o", key_o, pack4(m_key));
            check(iv_o === pack4(m_iv), "R2", "iv_o", iv_o, pack4(m_iv));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_key[i] = '0; m_din[i] = '0; m_iv[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1 reset state
        rd(8'h18, "R1");
        rd(8'h1C, "R1");
        chk_irq(1'b0, "R1");

        // R2 map and readback
        wr(8'h04, 32'hA5A5_0F0F);
        rd(8'h04, "R2");
        for (int w = 0; w < NW; w++) begin
            wr(8'h20 + 8'(4*w), 32'h1111_0000 + 32'(w));
            wr(8'h40 + 8'(4*w), 32'h2222_0000 + 32'(w));
            wr(8'h60 + 8'(4*w), 32'h3333_0000 + 32'(w));
        end
        rd(8'hFC, "R2");
        wr(8'hFC, 32'hDEAD_BEEF);
        rd(8'hFC, "R2");
        rd(8'h50, "R2");
        rd(8'h5C, "R2");

        // R7 write-only read returns zero and logs code 5
        rd(8'h24, "R7");
        rd(8'h1C, "R7");

        // R9 soft reset: bit0 clear ignored, bit0 set clears
        wr(8'h00, 32'h0000_0002);
        rd(8'h1C, "R9");
        wr(8'h00, 32'h0000_0001);
        rd(8'h1C, "R9");

        // R3 mask set/clear
        wr(8'h10, 32'h0000_0103);
        rd(8'h18, "R3");
        wr(8'h10, 32'h0);
        rd(8'h18, "R3");
        wr(8'h14, 32'h0000_0001);
        rd(8'h18, "R3");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h18, "R3");
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h18, "R3");

        // R4 status layout, R5 interrupt
        set_flags(5'b10101);
        rd(8'h1C, "R4");
        chk_irq(1'b0, "R5");
        wr(8'h10, 32'h0000_0004);
        chk_irq(1'b1, "R5");
        set_flags(5'b00000);
        chk_irq(1'b0, "R5");
        wr(8'h14, 32'hFFFF_FFFF);

        // R5 type field excluded; bit 8 drives irq
        wr(8'h10, 32'h0000_001F);
        rd(8'h10, "R7");
        chk_irq(1'b0, "R5");
        wr(8'h10, 32'h0000_0100);
        chk_irq(1'b1, "R5");
        wr(8'h00, 32'h0000_0001);
        rd(8'h18, "R9");
        chk_irq(1'b0, "R9");

        // R6 codes, R10 overwrite, R11 blocking
        phase(1'b1, 1'b0, 1'b1);
        wr(8'h44, 32'hBAD0_0001);
        rd(8'h1C, "R6");
        rd(8'h50, "R6");
        rd(8'h1C, "R10");
        wr(8'h04, 32'hBAD0_0002);
        rd(8'h1C, "R10");
        rd(8'h04, "R11");
        phase(1'b0, 1'b1, 1'b0);
        rd(8'h54, "R6");
        rd(8'h1C, "R10");
        wr(8'h04, 32'hBAD0_0003);
        rd(8'h1C, "R10");
        phase(1'b0, 1'b0, 1'b0);
        rd(8'h14, "R7");
        rd(8'h1C, "R10");

        // R8 lowest code wins
        phase(1'b1, 1'b1, 1'b0);
        rd(8'h58, "R8");
        rd(8'h1C, "R8");
        wr(8'h04, 32'hBAD0_0004);
        rd(8'h1C, "R8");

        // R11 input write while processing without DMA is legal
        phase(1'b1, 1'b0, 1'b0);
        wr(8'h48, 32'h600D_0001);
        rd(8'h1C, "R11");
        phase(1'b1, 1'b0, 1'b1);
        wr(8'h48, 32'hBAD0_0005);
        rd(8'h1C, "R11");
        phase(1'b0, 1'b0, 1'b0);
        wr(8'h04, 32'h0000_00C3);
        rd(8'h04, "R11");

        // R9 final clear
        wr(8'h00, 32'h0000_0001);
        rd(8'h1C, "R9");
        rd(8'h18, "R9");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule